// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Unit

This block holds the single per-processor reservation that software uses to build atomic read-modify-write sequences. A load-locked request is forwarded to the memory port as a read. At the same time it records the target quadword and sets a lock flag. A later store-conditional is forwarded as a write only if the flag is still up and the store falls in the same quadword. It always returns a 64-bit value for the destination register: 1 on success and 0 on failure. That value replaces the store data.

The reservation is dropped in three cases: an interrupt, an exception, or a snooped write from another agent that lands in the reserved quadword. Every store-conditional also drops it, whether the store happens or not. Longword and quadword sizes are both supported. A longword store drives only the four byte lanes it owns, so a neighbouring longword in the same quadword is left untouched. All memory-port outputs and the result are registered, and they appear one cycle after the request.

Top module: `llsc_reservation`

## Requirements
- R1: After reset no read, write or result is issued, and no reservation is held, so a store-conditional issued first fails.
- R2: A load-locked produces, one cycle later, a read with mem_addr equal to the request address and byte enables 8'hFF (quadword), 8'h0F (longword, address bit 2 = 0) or 8'hF0 (longword, address bit 2 = 1). It sets the reservation on that quadword.
- R3: A store-conditional with the reservation held and address bits [ADDR_W-1:3] equal to the reserved quadword writes memory one cycle later, and its result is 64'd1.
- R4: A store-conditional without a reservation, or to a different quadword, performs no memory write, and its result is 64'd0.
- R5: Every store-conditional clears the reservation, so a second store-conditional to the same address fails.
- R6: A snooped write to the reserved quadword clears the reservation. A snooped write to any other quadword leaves it intact.
- R7: An interrupt or an exception pulse clears the reservation.
- R8: An interrupt, an exception or a matching snooped write in the same cycle as a store-conditional forces that store-conditional to fail.
- R9: A load-locked while a reservation is held moves the reservation to the new quadword. The old quadword no longer matches.
- R10: A longword store writes its 32-bit data into both halves of mem_wdata with byte enables chosen by address bit 2. A quadword store passes all 64 bits with 8'hFF.
- R11: A load-locked in the same cycle as an interrupt or exception still reads, but it leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Load-locked request (one cycle; exclusive with sc_req) |
| sc_req | input | 1 | Store-conditional request (one cycle) |
| acc_quad | input | 1 | 1 = quadword access, 0 = longword |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| sc_data | input | 64 | Store-conditional data |
| snoop_wr | input | 1 | Write by another agent observed |
| snoop_qaddr | input | ADDR_W-3 | Quadword index of the snooped write |
| intr_evt | input | 1 | Interrupt taken |
| exc_evt | input | 1 | Exception taken |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 8 | Memory byte enables |
| mem_wdata | output | 64 | Memory write data |
| sc_done | output | 1 | Store-conditional result valid |
| sc_result | output | 64 | Value for the destination register (1 or 0) |

## Verification
The store-conditional is exercised after a clean load-locked, after no load-locked, after another store-conditional, and after each kind of clearing event: matching and non-matching snoops, interrupts and exceptions. Each of these events is also applied in the same cycle as the store-conditional. Together these patterns separate a flag that is never cleared from one that is cleared too eagerly. Longword stores at both halves of a quadword, and quadword stores, distinguish the lane selection. Back-to-back load-locked requests to two quadwords show whether the address is replaced or merely kept.

// File: rtl/llsc_reservation.sv
module llsc_reservation #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic              sc_req,
  input  logic              acc_quad,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [63:0]       sc_data,
  input  logic              snoop_wr,
  input  logic [ADDR_W-4:0] snoop_qaddr,
  input  logic              intr_evt,
  input  logic              exc_evt,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  output logic              sc_done,
  output logic [63:0]       sc_result
);
  localparam int QW = ADDR_W - 3;

  logic          lock_q;
  logic [QW-1:0] lock_qw_q;
  logic          pass_q;

  wire [QW-1:0] acc_qw   = acc_addr[ADDR_W-1:3];
  wire          trap     = intr_evt | exc_evt;
  wire          ll_go    = ll_req & ~sc_req;
  wire          kill     = trap | (snoop_wr & (snoop_qaddr == lock_qw_q));
  wire          ll_kill  = trap | (snoop_wr & (snoop_qaddr == acc_qw));
  wire          sc_ok    = sc_req & lock_q & ~kill & (acc_qw == lock_qw_q);
  wire [7:0]    be_next  = acc_quad ? 8'hFF : (acc_addr[2] ? 8'hF0 : 8'h0F);
  wire [63:0]   dat_next = acc_quad ? sc_data : {2{sc_data[31:0]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      lock_qw_q <= '0;
    end else if (ll_go) begin
      lock_q    <= ~ll_kill;
      lock_qw_q <= acc_qw;
    end else if (sc_req | kill) begin
      lock_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      sc_done   <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      mem_rd    <= ll_go;
      mem_wr    <= sc_ok;
      mem_addr  <= acc_addr;
      mem_be    <= be_next;
      mem_wdata <= dat_next;
      sc_done   <= sc_req;
      pass_q    <= sc_ok;
    end
  end

  assign sc_result = {63'd0, pass_q};

  AST_SC_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !lock_q); // R5
  AST_TRAP_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !lock_q); // R7
  AST_WR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(lock_q)); // R4
  AST_WR_ONLY_ON_SC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> sc_done); // R3
  AST_TRAP_FAILS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && trap) |=> (sc_done && !mem_wr)); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2
  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) >= 4)); // R10
endmodule

// File: tb/llsc_reservation_tb.sv
`timescale 1ns/1ps
module llsc_reservation_tb;
  localparam int AW = 40;

  typedef struct {
    logic          rd;
    logic          wr;
    logic [AW-1:0] addr;
    logic [7:0]    be;
    logic [63:0]   wdata;
    logic          done;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic ll_req = 0, sc_req = 0, acc_quad = 0, snoop_wr = 0, intr_evt = 0, exc_evt = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [63:0]   sc_data = '0;
  logic [AW-4:0] snoop_qaddr = '0;
  logic mem_rd, mem_wr, sc_done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_be;
  logic [63:0] mem_wdata, sc_result;

  int tests = 0, fails = 0;
  bit finished = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  llsc_reservation #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req), .acc_quad(acc_quad),
    .acc_addr(acc_addr), .sc_data(sc_data), .snoop_wr(snoop_wr), .snoop_qaddr(snoop_qaddr),
    .intr_evt(intr_evt), .exc_evt(exc_evt), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .sc_done(sc_done),
    .sc_result(sc_result));

  function automatic logic [7:0] lanes(logic quad, logic [AW-1:0] a);
    if (quad) return 8'hFF;
    return a[2] ? 8'hF0 : 8'h0F;
  endfunction

  task automatic op(input logic ll, input logic sc, input logic quad, input logic [AW-1:0] a,
                    input logic [63:0] d, input logic snp, input logic [AW-4:0] sq,
                    input logic irq, input logic exc, input logic ok, input string tag);
    exp_t e;
    @(negedge clk);
    ll_req = ll; sc_req = sc; acc_quad = quad; acc_addr = a; sc_data = d;
    snoop_wr = snp; snoop_qaddr = sq; intr_evt = irq; exc_evt = exc;
    if (ll || sc) begin
      e.rd = ll; e.wr = sc && ok; e.addr = a; e.be = lanes(quad, a);
      e.wdata = quad ? d : {2{d[31:0]}}; e.done = sc; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    ll_req = 0; sc_req = 0; snoop_wr = 0; intr_evt = 0; exc_evt = 0;
  endtask

  task automatic ll_op(input logic quad, input logic [AW-1:0] a, input string tag);
    op(1, 0, quad, a, 64'd0, 0, '0, 0, 0, 0, tag);
  endtask

  task automatic sc_op(input logic quad, input logic [AW-1:0] a, input logic [63:0] d,
                       input logic ok, input string tag);
    op(0, 1, quad, a, d, 0, '0, 0, 0, ok, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished && (mem_rd || mem_wr || sc_done)) begin
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected output: rd=%0b wr=%0b done=%0b, expected none", mem_rd, mem_wr, sc_done);
      end else begin
        exp_t e;
        logic bad;
        e = q.pop_front();
        bad = (mem_rd !== e.rd) || (mem_wr !== e.wr) || (sc_done !== e.done);
        if (e.rd || e.wr) bad = bad || (mem_addr !== e.addr) || (mem_be !== e.be);
        if (e.wr) bad = bad || (mem_wdata !== e.wdata);
        if (e.done) bad = bad || (sc_result !== {63'd0, e.wr});
        if (bad)
          $display("FAIL %s: rd=%0b wr=%0b addr=%h be=%h wd=%h done=%0b res=%0d, expected rd=%0b wr=%0b addr=%h be=%h wd=%h done=%0b res=%0d",
                   e.tag, mem_rd, mem_wr, mem_addr, mem_be, mem_wdata, sc_done, sc_result,
                   e.rd, e.wr, e.addr, e.be, e.wdata, e.done, e.wr);
        if (bad) fails++;
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] A, B;
    A = 40'h10_0000_1000;
    B = 40'h10_0000_2000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (mem_rd !== 0 || mem_wr !== 0 || sc_done !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs rd=%0b wr=%0b done=%0b, expected 0 0 0", mem_rd, mem_wr, sc_done);
    end
    sc_op(1, A, 64'h1111, 0, "R1 sc after reset");
    ll_op(1, A, "R2 ll quad");
    sc_op(1, A, 64'hDEAD_BEEF_0123_4567, 1, "R3 sc success quad");
    sc_op(1, A, 64'h2222, 0, "R5 second sc fails");
    ll_op(1, A, "R2 ll");
    sc_op(1, B, 64'h3333, 0, "R4 sc other quadword");
    ll_op(0, A + 4, "R2 ll longword high");
    sc_op(0, A + 4, 64'h0000_0000_CAFE_F00D, 1, "R10 sc longword high");
    ll_op(0, A, "R2 ll longword low");
    sc_op(0, A, 64'h0000_0000_1234_5678, 1, "R10 sc longword low");
    ll_op(1, A, "R6 ll");
    op(0, 0, 0, '0, '0, 1, B[AW-1:3], 0, 0, 0, "R6 snoop elsewhere");
    sc_op(1, A, 64'h4444, 1, "R6 sc survives foreign snoop");
    ll_op(1, A, "R6 ll");
    op(0, 0, 0, '0, '0, 1, A[AW-1:3], 0, 0, 0, "R6 snoop match");
    sc_op(1, A, 64'h5555, 0, "R6 sc after matching snoop");
    ll_op(1, A, "R7 ll");
    op(0, 0, 0, '0, '0, 0, '0, 1, 0, 0, "R7 interrupt");
    sc_op(1, A, 64'h6666, 0, "R7 sc after interrupt");
    ll_op(1, A, "R7 ll");
    op(0, 0, 0, '0, '0, 0, '0, 0, 1, 0, "R7 exception");
    sc_op(1, A, 64'h7777, 0, "R7 sc after exception");
    ll_op(1, A, "R8 ll");
    op(0, 1, 1, A, 64'h8888, 0, '0, 1, 0, 0, "R8 sc with interrupt");
    ll_op(1, A, "R8 ll");
    op(0, 1, 1, A, 64'h9999, 1, A[AW-1:3], 0, 0, 0, "R8 sc with snoop");
    ll_op(1, A, "R8 ll");
    op(0, 1, 1, A, 64'hAAAA, 0, '0, 0, 1, 0, "R8 sc with exception");
    ll_op(1, A, "R9 ll old");
    ll_op(1, B, "R9 ll new");
    sc_op(1, A, 64'hBBBB, 0, "R9 sc old address");
    ll_op(1, A, "R9 ll old");
    ll_op(1, B, "R9 ll new");
    sc_op(1, B, 64'hCCCC_0000_DDDD_0000, 1, "R9 sc new address");
    op(1, 0, 1, A, '0, 0, '0, 1, 0, 0, "R11 ll with interrupt");
    sc_op(1, A, 64'hEEEE, 0, "R11 sc after killed ll");
    repeat (3) @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3 missing outputs: %0d pending, expected 0", q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule